// File: doc/BRIEF.md
# Serial Link Transmitter Self-Test Controller

This block sits between the 8B/10B encoder and the serializer of a byte-oriented serial-link transmitter. It runs on the bit clock and divides it into byte slots of `SLOTS` clocks. At each slot boundary it samples its control inputs and one encoded code group, and for that byte it chooses what goes to the serializer. In normal operation the encoded code group passes through. In the constant self-test mode a fixed code group is sent, which puts an alternating 1-0 pattern on the line. In the loop self-test mode a 511-byte pseudo-random sequence is sent that a matching receiver can check.

The block also produces an active-low read strobe for the upstream FIFO. The strobe's low time is a count of bit clocks, so its duty cycle does not depend on the duty cycle of any byte-rate clock. In loop mode the strobe fires once per loop, during the last byte. A flag marks that same byte.

The sequence generator runs on its own and needs no start-up. A restart request, honoured only while self-test is enabled, makes the next byte the first byte of the loop.

Top module: `link_selftest_ctl`

## Requirements
- R1: While `rst_n` is low: `code_o` is 0, `last_o` is 0 and `rd_n` is 1.
- R2: Inputs are sampled only on the clock edge that ends a byte slot, one edge in every `SLOTS`. `code_o` and `last_o` change only on that edge, so a code group is never cut short by a change of input in mid-byte.
- R3: Normal mode (`test_n`=1): `code_o` holds the `enc_code` value sampled at the start of the byte.
- R4: Normal mode: when `data_en` was sampled high, `rd_n` is low for the first `LOW_SLOTS` clocks of the byte (6 of 10 by default) and high for the rest. When `data_en` was sampled low, `rd_n` stays high.
- R5: Constant test mode (`test_n`=0, `data_en`=1 and `ctl_en`=1): `code_o` is `ALT_CODE` (default 10'b0101010101) on every byte, `rd_n` stays high and `last_o` stays low.
- R6: Loop test mode (`test_n`=0 and `data_en` or `ctl_en` low): `code_o` is `{s, ^s}`, where s is the 9-bit sequence state of the byte in bits 9..1 and bit 0 is its even parity. The state steps as s' = {s[7:0], s[8]^s[4]}, so the sequence repeats every 511 bytes.
- R7: `last_o` is high for exactly the loop-mode byte whose state is all ones (the last byte of the loop). It is low in every other byte.
- R8: In loop mode `rd_n` is low for the first `LOW_SLOTS` clocks of the last byte of the loop and high in every other byte.
- R9: When `seq_rst`=1 and `test_n`=0 are sampled together, the byte takes state 9'h1FE, the first byte of the loop. When `test_n`=1, `seq_rst` has no effect.
- R10: The sequence state advances once per byte in every mode, so a return to loop mode continues from where the free-running sequence has got to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one byte slot lasts SLOTS cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_en | input | 1 | Data enable strobe, active high |
| ctl_en | input | 1 | Control enable strobe, active high |
| test_n | input | 1 | Self-test enable, active low |
| seq_rst | input | 1 | Request to restart the test sequence |
| enc_code | input | CW | Encoded code group from the encoder |
| code_o | output | CW | Code group to the serializer |
| last_o | output | 1 | High during the last byte of a test loop |
| rd_n | output | 1 | Active-low FIFO read strobe |

## Verification
Normal mode is run with two different encoded words and with data enable both high and low. This separates pass-through from strobe gating. Constant mode is checked over several bytes to confirm the fixed group and a silent strobe. Loop mode starts from a restart and runs for more than one full period. This shows the sequence content, a 511-byte period with a single flagged byte, and a read strobe only in that byte. A mid-byte change of mode, and a restart request made outside test mode while the sequence runs on, show that outputs move only at slot boundaries and that the generator runs freely without honouring the request.

// File: rtl/link_selftest_ctl.sv
module link_selftest_ctl #(
  parameter int CW = 10,
  parameter int LW = 9,
  parameter int TAP = 5,
  parameter int SLOTS = 10,
  parameter int LOW_SLOTS = 6,
  parameter logic [CW-1:0] ALT_CODE = 10'b0101010101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_en,
  input  logic          ctl_en,
  input  logic          test_n,
  input  logic          seq_rst,
  input  logic [CW-1:0] enc_code,
  output logic [CW-1:0] code_o,
  output logic          last_o,
  output logic          rd_n
);
  localparam int PW = $clog2(SLOTS);
  localparam logic [PW-1:0] PH_LAST = PW'(SLOTS - 1);
  localparam logic [PW-1:0] PH_LOW = PW'(LOW_SLOTS);
  localparam logic [LW-1:0] ONES = '1;
  localparam logic [LW-1:0] START = {ONES[LW-2:0], 1'b0};

  typedef enum logic [1:0] {M_NORM, M_ALT, M_LOOP} mode_t;

  logic [PW-1:0] phase, phase_nx;
  logic [LW-1:0] lfsr, lfsr_adv, lfsr_nx;
  mode_t mode, mode_nx;
  logic pen, pen_nx, boundary;

  assign boundary = (phase == PH_LAST);
  assign phase_nx = boundary ? '0 : phase + 1'b1;
  assign lfsr_adv = {lfsr[LW-2:0], lfsr[LW-1] ^ lfsr[TAP-1]};
  assign lfsr_nx = (!test_n && seq_rst) ? START : lfsr_adv;
  assign mode_nx = test_n ? M_NORM : ((data_en && ctl_en) ? M_ALT : M_LOOP);

  always_comb begin
    pen_nx = pen;
    if (boundary) begin
      case (mode_nx)
        M_NORM:  pen_nx = data_en;
        M_LOOP:  pen_nx = (lfsr_nx == ONES);
        default: pen_nx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      lfsr   <= ONES;
      mode   <= M_NORM;
      pen    <= 1'b0;
      code_o <= '0;
      last_o <= 1'b0;
      rd_n   <= 1'b1;
    end else begin
      phase <= phase_nx;
      pen   <= pen_nx;
      rd_n  <= ~(pen_nx && (phase_nx < PH_LOW));
      if (boundary) begin
        lfsr   <= lfsr_nx;
        mode   <= mode_nx;
        last_o <= (mode_nx == M_LOOP) && (lfsr_nx == ONES);
        case (mode_nx)
          M_NORM:  code_o <= enc_code;
          M_ALT:   code_o <= ALT_CODE;
          default: code_o <= CW'({lfsr_nx, ^lfsr_nx});
        endcase
      end
    end
  end

  // R2: the serializer word and the loop flag move only at slot ends
  a_r2_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_LAST) |=> ($stable(code_o) && $stable(last_o)));
  a_r4_strobe_starts_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (phase == '0));
  a_r5_alt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ALT) |-> (rd_n && !last_o && code_o == ALT_CODE));
  a_r7_last_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (mode == M_LOOP));
  a_r8_loop_read_once: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_LOOP) && !rd_n) |-> last_o);
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !test_n && seq_rst) |=> (lfsr == START));
  a_r10_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: tb/link_selftest_ctl_test.sv
module link_selftest_ctl_test;
  localparam int CLK_P = 10;
  localparam int SLOTS = 10;
  localparam int LOWS = 6;
  localparam logic [9:0] ALT = 10'b0101010101;
  localparam logic [8:0] START = 9'h1FE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_en = 1'b0, ctl_en = 1'b0, test_n = 1'b1, seq_rst = 1'b0;
  logic [9:0] enc_code = '0;
  logic [9:0] code_o;
  logic last_o, rd_n;

  int checks = 0, fails = 0, edges = 0;
  bit done = 0;
  logic [9:0] b_code;
  logic b_last;
  int b_low;
  logic [8:0] s;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  link_selftest_ctl uut (.clk(clk), .rst_n(rst_n), .data_en(data_en), .ctl_en(ctl_en),
    .test_n(test_n), .seq_rst(seq_rst), .enc_code(enc_code), .code_o(code_o),
    .last_o(last_o), .rd_n(rd_n));

  function automatic logic [8:0] step(logic [8:0] x);
    return {x[7:0], x[8] ^ x[4]};
  endfunction
  function automatic logic [9:0] lmap(logic [8:0] x);
    return {x, ^x};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic byte_start();
    do @(negedge clk); while (edges % SLOTS != 0);
  endtask

  task automatic observe_byte();
    b_code = code_o;
    b_last = last_o;
    b_low = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (i > 0) @(negedge clk);
      if (!rd_n) b_low++;
    end
  endtask

  task automatic t_reset();
    check("R1 code", code_o, 0);
    check("R1 last", last_o, 0);
    check("R1 rd_n", rd_n, 1);
  endtask

  task automatic t_normal();
    test_n = 1; data_en = 1; ctl_en = 1; enc_code = 10'h2A7;
    byte_start(); observe_byte();
    check("R3 code", b_code, 10'h2A7);
    check("R4 low slots", b_low, LOWS);
    check("R7 last normal", b_last, 0);
    enc_code = 10'h15C;
    byte_start(); observe_byte();
    check("R3 code second", b_code, 10'h15C);
    check("R4 low slots second", b_low, LOWS);
    data_en = 0; enc_code = 10'h0F3;
    byte_start(); observe_byte();
    check("R3 code gated", b_code, 10'h0F3);
    check("R4 no strobe", b_low, 0);
  endtask

  task automatic t_alt();
    int bad = 0;
    test_n = 0; data_en = 1; ctl_en = 1;
    for (int k = 0; k < 4; k++) begin
      byte_start(); observe_byte();
      if (b_code !== ALT || b_low != 0 || b_last !== 0) bad++;
    end
    check("R5 constant pattern", bad, 0);
  endtask

  task automatic t_loop();
    int bad_c = 0, bad_r = 0, nlast = 0, where = -1;
    test_n = 0; ctl_en = 0; seq_rst = 1;
    byte_start();
    seq_rst = 0;
    s = START;
    for (int k = 0; k < 520; k++) begin
      if (k > 0) byte_start();
      observe_byte();
      if (b_code !== lmap(s)) bad_c++;
      if (b_last !== (s == 9'h1FF)) bad_c++;
      if (b_low != ((s == 9'h1FF) ? LOWS : 0)) bad_r++;
      if (b_last === 1'b1) begin nlast++; where = k; end
      s = step(s);
    end
    check("R6 sequence content", bad_c, 0);
    check("R8 strobe placement", bad_r, 0);
    check("R7 one last per loop", nlast, 1);
    check("R6 period 511", where, 510);
  endtask

  task automatic t_restart_free();
    test_n = 0; ctl_en = 0; seq_rst = 1;
    byte_start(); seq_rst = 0; observe_byte();
    check("R9 restart", b_code, lmap(START));
    s = START;
    for (int k = 0; k < 3; k++) begin byte_start(); observe_byte(); s = step(s); end
    check("R6 after restart", b_code, lmap(s));
    test_n = 1; seq_rst = 1; data_en = 1; enc_code = 10'h111;
    for (int k = 0; k < 2; k++) begin byte_start(); observe_byte(); s = step(s); end
    check("R9 ignored outside test", b_code, 10'h111);
    test_n = 0; seq_rst = 0; data_en = 0;
    byte_start(); observe_byte(); s = step(s);
    check("R10 free running", b_code, lmap(s));
  endtask

  task automatic t_midbyte();
    int bad = 0;
    test_n = 1; data_en = 1; enc_code = 10'h3C3;
    byte_start();
    repeat (3) @(negedge clk);
    test_n = 0; ctl_en = 1;
    for (int i = 3; i < SLOTS; i++) begin
      if (code_o !== 10'h3C3) bad++;
      @(negedge clk);
    end
    check("R2 no truncation", bad, 0);
    check("R2 switch at boundary", code_o, ALT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_normal();
    t_alt();
    t_loop();
    t_restart_free();
    t_midbyte();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule